// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a processor access to a bank of up to 32 internal byte-wide registers through just two registers that the processor can see. The first is a control register that holds an offset and a transfer direction. The second is a data register.

A control write with the direction bit set starts a read at once. A control write with the direction bit clear only arms a write. That write goes out when the processor next loads the data register. Each transfer is carried to the register bank over a request/acknowledge port. The bank may take any number of cycles to acknowledge. A busy flag in the control register stays high for the whole transfer, and control writes are dropped while it is high.

Offset zero means "no operation". Offset 0x0F and offsets 0x15 to 0x1F are unused. An operation at any of these completes in one busy cycle without touching the back end.

Top module: `ireg_bridge`

## Requirements
- R1: After reset, the control view `ctl_q` reads 0x00, `data_q` reads 0x00 and `be_req` is low.
- R2: `ctl_q` shows the direction bit in bit 7 (1 = read), busy in bit 6, a constant 0 in bit 5, and the offset in bits 4:0. Bits 6 and 5 of a control write are ignored.
- R3: A control write with bit 7 = 1, made while not busy, raises busy on the next cycle. For a valid offset it also raises `be_req` on that cycle, with `be_we` = 0 and `be_addr` equal to the offset.
- R4: A control write with bit 7 = 0 starts nothing. Busy and `be_req` stay low until the data register is loaded. That load raises busy and `be_req` (with `be_we` = 1) on the next cycle and sends the loaded byte as `be_wdata`.
- R5: For a valid offset, busy stays high from the start of a transfer until the cycle after `be_ack` is seen. With an ack that comes N cycles after the request rises, busy lasts N+1 cycles.
- R6: A control write made while busy is 1 changes nothing. The offset, the direction and the transfer in flight are kept.
- R7: Offsets 0x00, 0x0F and 0x15 to 0x1F never raise `be_req`. Busy is high for exactly one cycle, and a read at such an offset leaves 0x00 in `data_q`.
- R8: While `be_req` is high and `be_ack` is low, `be_req`, `be_we`, `be_addr` and `be_wdata` hold their values.
- R9: On the cycle busy clears after a read, `data_q` holds the byte returned on `be_rdata` with the ack.
- R10: A data-register load made with no write armed, or while busy, only updates `data_q`. It starts no transfer and does not change `be_wdata` while a write is in flight.
- R11: A control write made while a write is armed (and not busy) replaces the armed offset. The later data load goes to the new offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_sel | input | 1 | Register select for a write: 0 = control, 1 = data |
| cpu_wdata | input | 8 | Processor write byte |
| ctl_q | output | 8 | Control register read view |
| data_q | output | 8 | Data register read view |
| be_req | output | 1 | Back-end request, held until acknowledged |
| be_we | output | 1 | Back-end direction: 1 = write |
| be_addr | output | 5 | Back-end register offset |
| be_wdata | output | 8 | Back-end write byte |
| be_ack | input | 1 | Back-end acknowledge |
| be_rdata | input | 8 | Back-end read byte, valid with the acknowledge |

## Verification
After a processor write at a clock edge, `ctl_q`, busy and `be_req` show the new state one cycle later. The bench checks them on the falling edge that follows its write strobe. A valid transfer ends one cycle after the ack edge, so the bench polls busy on each falling edge and checks `data_q` and its back-end transaction log on the first cycle busy reads low. A transfer at an unused offset must end on the second falling edge after the strobe, which fixes the expected busy count at one. The back-end model acknowledges after a random 0 to 3 cycles, or after a fixed delay in the directed cases, so the expected busy length is delay plus one.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,   // nothing armed
    ST_PEND,   // write armed, waiting for data load
    ST_REQ,    // back-end request outstanding
    ST_NOP     // null offset, one busy cycle
  } seq_st_t;
endpackage

// File: rtl/ireg_ofs_chk.sv
module ireg_ofs_chk #(
  parameter int ADDR_W   = 5,
  parameter int HOLE_OFS = 15,
  parameter int LAST_OFS = 20
) (
  input  logic [ADDR_W-1:0] ofs,
  output logic              ofs_ok
);
  localparam logic [ADDR_W-1:0] HOLE = ADDR_W'(HOLE_OFS);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_OFS);

  always_comb begin
    ofs_ok = (ofs != '0) && (ofs != HOLE) && (ofs <= LAST);
  end
endmodule

// File: rtl/ireg_seq.sv
module ireg_seq
  import ireg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ctl_acc,
  input  logic ctl_rw,
  input  logic dat_wr,
  input  logic ofs_ok,
  input  logic be_ack,
  output logic busy,
  output logic be_req,
  output logic be_we,
  output logic rd_load,
  output logic rd_clear,
  output logic wr_start
);
  seq_st_t st_q;
  logic    op_rd_q;

  assign wr_start = (st_q == ST_PEND) && dat_wr;
  assign rd_load  = (st_q == ST_REQ) && be_ack && op_rd_q;
  assign rd_clear = (st_q == ST_NOP) && op_rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      op_rd_q <= 1'b0;
      busy    <= 1'b0;
      be_req  <= 1'b0;
      be_we   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE, ST_PEND: begin
          if (ctl_acc) begin
            op_rd_q <= ctl_rw;
            if (ctl_rw) begin
              busy <= 1'b1;
              if (ofs_ok) begin
                st_q   <= ST_REQ;
                be_req <= 1'b1;
                be_we  <= 1'b0;
              end else begin
                st_q <= ST_NOP;
              end
            end else begin
              st_q <= ST_PEND;
            end
          end else if (wr_start) begin
            op_rd_q <= 1'b0;
            busy    <= 1'b1;
            if (ofs_ok) begin
              st_q   <= ST_REQ;
              be_req <= 1'b1;
              be_we  <= 1'b1;
            end else begin
              st_q <= ST_NOP;
            end
          end
        end
        ST_REQ: begin
          if (be_ack) begin
            st_q   <= ST_IDLE;
            busy   <= 1'b0;
            be_req <= 1'b0;
            be_we  <= 1'b0;
          end
        end
        default: begin
          st_q <= ST_IDLE;
          busy <= 1'b0;
        end
      endcase
    end
  end

  p_req_busy_r5: assert property (@(posedge clk) disable iff (rst)
    be_req |-> busy);
  p_nop_one_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !be_req) |=> !busy);
  p_we_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (be_req && !be_ack) |=> (be_req && $stable(be_we)));
endmodule

// File: rtl/ireg_datareg.sv
module ireg_datareg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              wr_start,
  input  logic              rd_load,
  input  logic              rd_clear,
  input  logic [DATA_W-1:0] be_rdata,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] wbuf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      wbuf_q <= '0;
    end else begin
      if (rd_load)      data_q <= be_rdata;
      else if (rd_clear) data_q <= '0;
      else if (dat_wr)   data_q <= cpu_wdata;
      if (wr_start) wbuf_q <= cpu_wdata;
    end
  end
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8,
  parameter int HOLE_OFS = 15,
  parameter int LAST_OFS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic              cpu_sel,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0] data_q,
  output logic              be_req,
  output logic              be_we,
  output logic [ADDR_W-1:0] be_addr,
  output logic [DATA_W-1:0] be_wdata,
  input  logic              be_ack,
  input  logic [DATA_W-1:0] be_rdata
);
  localparam int PAD_W = DATA_W - ADDR_W - 2;
  localparam logic [ADDR_W-1:0] HOLE = ADDR_W'(HOLE_OFS);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_OFS);

  logic              busy, ctl_acc, dat_wr, ofs_ok;
  logic              rd_load, rd_clear, wr_start;
  logic              rw_q;
  logic [ADDR_W-1:0] addr_q, start_ofs;

  assign ctl_acc   = cpu_wr && !cpu_sel && !busy;
  assign dat_wr    = cpu_wr && cpu_sel;
  assign start_ofs = ctl_acc ? cpu_wdata[ADDR_W-1:0] : addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rw_q   <= 1'b0;
      addr_q <= '0;
    end else if (ctl_acc) begin
      rw_q   <= cpu_wdata[DATA_W-1];
      addr_q <= cpu_wdata[ADDR_W-1:0];
    end
  end

  assign ctl_q   = {rw_q, busy, {PAD_W{1'b0}}, addr_q};
  assign be_addr = addr_q;

  ireg_ofs_chk #(
    .ADDR_W(ADDR_W), .HOLE_OFS(HOLE_OFS), .LAST_OFS(LAST_OFS)
  ) u_ofs (
    .ofs(start_ofs), .ofs_ok(ofs_ok)
  );

  ireg_seq u_seq (
    .clk(clk), .rst(rst), .ctl_acc(ctl_acc), .ctl_rw(cpu_wdata[DATA_W-1]),
    .dat_wr(dat_wr), .ofs_ok(ofs_ok), .be_ack(be_ack), .busy(busy),
    .be_req(be_req), .be_we(be_we), .rd_load(rd_load), .rd_clear(rd_clear),
    .wr_start(wr_start)
  );

  ireg_datareg #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .dat_wr(dat_wr), .cpu_wdata(cpu_wdata),
    .wr_start(wr_start), .rd_load(rd_load), .rd_clear(rd_clear),
    .be_rdata(be_rdata), .data_q(data_q), .wbuf_q(be_wdata)
  );

  p_ctl_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(addr_q) && $stable(rw_q)));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (be_req && !be_ack) |=> ($stable(be_addr) && $stable(be_wdata)));
  p_noreq_null_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(be_req) |-> ((be_addr != '0) && (be_addr != HOLE) && (be_addr <= LAST)));
  p_rd_latch_r9: assert property (@(posedge clk) disable iff (rst)
    (be_req && be_ack && !be_we) |=> (data_q == $past(be_rdata)));
endmodule

// File: tb/ireg_bridge_bench.sv
module ireg_bridge_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr = 1'b0, cpu_sel = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] ctl_q, data_q, be_wdata;
  logic       be_req, be_we;
  logic [4:0] be_addr;
  logic       be_ack = 1'b0;
  logic [7:0] be_rdata = '0;

  int checks = 0, errors = 0;
  logic [7:0] mem [32];
  logic [7:0] shadow [32];
  int force_delay = -1, bdelay = 0, n_req = 0, n_wr = 0, stab_err = 0;
  logic seen = 1'b0;
  logic [4:0] last_wa = '0, snap_a = '0;
  logic [7:0] last_wd = '0, snap_d = '0;
  logic       snap_w = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ireg_bridge u_ireg_bridge (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .ctl_q(ctl_q), .data_q(data_q), .be_req(be_req),
    .be_we(be_we), .be_addr(be_addr), .be_wdata(be_wdata), .be_ack(be_ack),
    .be_rdata(be_rdata)
  );

  // back-end register bank model
  always @(negedge clk) begin
    if (rst) begin
      be_ack = 1'b0;
      seen   = 1'b0;
    end else if (be_ack) begin
      be_ack = 1'b0;
    end else if (be_req) begin
      if (!seen) begin
        seen   = 1'b1;
        bdelay = (force_delay >= 0) ? force_delay : int'($urandom % 4);
        snap_a = be_addr; snap_d = be_wdata; snap_w = be_we;
      end else if (be_addr !== snap_a || be_wdata !== snap_d || be_we !== snap_w) begin
        stab_err++;
      end
      if (bdelay == 0) begin
        be_ack = 1'b1;
        seen   = 1'b0;
        n_req++;
        if (be_we) begin
          mem[be_addr] = be_wdata;
          last_wa = be_addr; last_wd = be_wdata; n_wr++;
        end else begin
          be_rdata = mem[be_addr];
        end
      end else begin
        bdelay--;
      end
    end
  end

  function automatic bit ofs_valid(input logic [4:0] o);
    return (o != 5'h00) && (o != 5'h0F) && (o <= 5'h14);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic sel, input logic [7:0] v);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = v;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic wait_idle(output int c);
    c = 0;
    while (ctl_q[6] === 1'b1 && c < 1000) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic do_read(input logic [4:0] o);
    int n0, c;
    n0 = n_req;
    cpu_write(1'b0, {3'b100, o});
    chk("R3 busy after read start", ctl_q[6], 1'b1);
    if (ofs_valid(o)) chk("R3 req/we/addr", {be_req, be_we, be_addr}, {1'b1, 1'b0, o});
    else chk("R7 no req at null offset", be_req, 1'b0);
    wait_idle(c);
    chk("R9 read data", data_q, ofs_valid(o) ? shadow[o] : 8'h00);
    chk("R7 request count", n_req - n0, ofs_valid(o) ? 1 : 0);
    if (!ofs_valid(o)) chk("R7 one busy cycle", c, 1);
  endtask

  task automatic do_write(input logic [4:0] o, input logic [7:0] d);
    int n0, w0, c;
    n0 = n_req; w0 = n_wr;
    cpu_write(1'b0, {3'b000, o});
    chk("R4 armed not busy", ctl_q[6], 1'b0);
    @(negedge clk);
    chk("R4 no req before load", be_req, 1'b0);
    cpu_write(1'b1, d);
    chk("R4 busy after load", ctl_q[6], 1'b1);
    wait_idle(c);
    if (ofs_valid(o)) begin
      chk("R4 write count", n_wr - w0, 1);
      chk("R4 write addr/data", {last_wa, last_wd}, {o, d});
      shadow[o] = d;
    end else begin
      chk("R7 no req for null write", n_req - n0, 0);
      chk("R7 one busy cycle", c, 1);
    end
    chk("R10 data reg holds loaded byte", data_q, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c, n0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) begin
      mem[i] = 8'(i * 29 + 3);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ctl", ctl_q, 8'h00);
    chk("R1 reset data", data_q, 8'h00);
    chk("R1 reset req", be_req, 1'b0);

    // R2: bits 6 and 5 of a control write ignored
    cpu_write(1'b0, 8'h6C);
    chk("R2 ctl view", ctl_q, 8'h0C);
    cpu_write(1'b0, 8'hE5);
    chk("R2 ctl view on read", {ctl_q[7:5], ctl_q[4:0]}, {3'b110, 5'h05});
    wait_idle(c);
    chk("R9 read after masked ctl", data_q, shadow[5]);

    // R5: busy length = delay + 1
    force_delay = 3;
    cpu_write(1'b0, 8'h82);
    wait_idle(c);
    chk("R5 busy cycles", c, 4);
    chk("R9 data", data_q, shadow[2]);

    // R6: control write while busy is dropped
    force_delay = 6;
    n0 = n_req;
    cpu_write(1'b0, 8'h83);
    cpu_write(1'b0, 8'h05);
    chk("R6 ctl unchanged while busy", ctl_q, 8'hC3);
    wait_idle(c);
    chk("R6 original read done", data_q, shadow[3]);
    chk("R6 single request", n_req - n0, 1);

    // R10: data load with nothing armed
    n0 = n_req;
    cpu_write(1'b1, 8'h5A);
    chk("R10 idle load data", data_q, 8'h5A);
    chk("R10 idle load no busy", {ctl_q[6], be_req}, 2'b00);
    repeat (2) @(negedge clk);
    chk("R10 idle load no request", n_req - n0, 0);

    // R10: data load during a write in flight
    force_delay = 5;
    cpu_write(1'b0, 8'h07);
    cpu_write(1'b1, 8'h11);
    cpu_write(1'b1, 8'h22);
    chk("R10 data updated while busy", data_q, 8'h22);
    chk("R10 wdata held while busy", be_wdata, 8'h11);
    wait_idle(c);
    chk("R10 written byte", {last_wa, last_wd}, {5'h07, 8'h11});
    shadow[7] = 8'h11;
    chk("R10 data after write", data_q, 8'h22);
    force_delay = -1;

    // R11: re-arming retargets the write
    cpu_write(1'b0, 8'h04);
    cpu_write(1'b0, 8'h06);
    cpu_write(1'b1, 8'h33);
    wait_idle(c);
    chk("R11 retargeted write", {last_wa, last_wd}, {5'h06, 8'h33});
    shadow[6] = 8'h33;

    // R7: directed null offsets
    do_read(5'h00);
    do_read(5'h0F);
    do_read(5'h15);
    do_read(5'h1F);
    do_write(5'h0F, 8'hA5);
    do_read(5'h14);
    do_write(5'h01, 8'hC3);
    do_read(5'h01);

    // random mix
    for (int i = 0; i < 150; i++) begin
      logic [4:0] o;
      o = 5'($urandom % 32);
      if ($urandom % 2) do_read(o);
      else do_write(o, 8'($urandom));
    end

    chk("R8 request qualifiers stable", stab_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule